// File: doc/BRIEF.md
# E1 Channel-Associated Signaling Extractor

This block pulls per-channel signaling out of the timeslot-16 octets of an E1 link. Each octet arrives with the number of the frame it belongs to within the 16-frame multiframe. Frame 0 carries the multiframe alignment word, and the block discards it. Each of frames 1 to 15 carries two signaling nibbles, one for a low channel and one for a high channel. The nibbles collect in a pending buffer. When the frame-15 octet is accepted, every channel commits its new value at once, so a read always returns a full multiframe's worth of signaling.

Each of the 30 voice channels has a two-bit mode. The mode either freezes the channel or keeps all four bits, two bits, or one bit of the nibble. At the commit, each active channel compares its masked new value with the value it already holds. If any active channel differs, a sticky change flag is set. The flag drives the interrupt pin only when both a signaling-change enable and a block-level enable are on.

Software sets modes and enables, reads stored values and clears the flag through a plain write port and a separate combinational read port. The octet input is valid/ready. The block never applies back-pressure: `in_ready` is high whenever reset is released. Gaps in `in_valid` are allowed and change nothing.

Top module: `e1_cas_extract`

## Requirements
- R1: After reset, every stored nibble, every mode, both enables and the change flag read 0, `irq` is 0, and `in_ready` is 1.
- R2: An octet is taken only in a cycle where `in_valid` and `in_ready` are both 1. Octets tagged frame 0 affect no stored value and no flag.
- R3: The octet of frame f (1..15) carries channel f in bits [7:4] and channel f+15 in bits [3:0]. Within a nibble, bit 3 is A, bit 2 is B, bit 1 is C and bit 0 is D.
- R4: Mode 01 (sixteen-code) stores all four bits A B C D.
- R5: Mode 10 (four-code) stores A and B and stores C and D as 0.
- R6: Mode 11 (two-code) stores A and stores B, C and D as 0.
- R7: Mode 00 freezes the channel's stored value, and the channel never sets the change flag.
- R8: Stored values change only on the clock edge that accepts the frame-15 octet. Before that edge, reads return the previous multiframe's values.
- R9: On that edge, the change flag is set if any channel in a nonzero mode has a masked new value that differs from its stored value.
- R10: The change flag stays set until a write of 1 to status bit 0 clears it. A set on the same edge as the clear wins.
- R11: `irq` is 1 exactly when the change flag, control bit 0 (signaling-change enable) and control bit 1 (block enable) are all 1.
- R12: Register map, with a write taking effect at the clock edge and reads combinational on `rd_addr`:
  - Addresses 0..29 map to channels 1..30. Write data bits [1:0] set the channel's mode. A read returns the mode in [7:6] and the stored nibble in [3:0].
  - Address 0x20 is the control register.
  - Address 0x21 is the status register, with the flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Timeslot-16 octet valid |
| in_ready | output | 1 | Octet accepted when high with in_valid |
| in_frame | input | 4 | Frame number in multiframe, 0..15 |
| in_octet | input | 8 | Timeslot-16 octet |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Read data, combinational |
| irq | output | 1 | Gated change-of-signaling interrupt |

## Verification
A wrong pending nibble stays hidden until the next frame-15 edge. It then shows on the channel reads at that edge, and it can also set the flag where none was due. A wrong mode mask shows in the same cycle as a nonzero C, D or B bit in a stored value, or as a flag raised by bits that should have been discarded. A bad flag or enable state shows on `irq` and the status read one cycle after the commit or write that should have changed it. A frozen channel that moves is caught at the first commit after its mode was set to 0.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;
  localparam int NIB_W = 4;

  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_16  = 2'b01;
  localparam logic [1:0] MODE_4   = 2'b10;
  localparam logic [1:0] MODE_2   = 2'b11;

  // Keep the signaling bits the mode allows; A is bit 3.
  function automatic logic [NIB_W-1:0] mask_nibble(input logic [1:0] mode,
                                                  input logic [NIB_W-1:0] raw);
    logic [NIB_W-1:0] r;
    case (mode)
      MODE_16: r = raw;
      MODE_4:  r = {raw[3:2], 2'b00};
      MODE_2:  r = {raw[3], 3'b000};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/e1cas_capture.sv
module e1cas_capture
  import e1cas_pkg::*;
#(
  parameter int NUM_CH = 30,
  localparam int HALF  = NUM_CH / 2,
  localparam int FRM_W = $clog2(HALF + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take,
  input  logic [FRM_W-1:0]            frame,
  input  logic [2*NIB_W-1:0]          octet,
  output logic [NUM_CH-1:0][NIB_W-1:0] raw,
  output logic                        commit
);
  logic [NUM_CH-1:0][NIB_W-1:0] pend_q;
  logic                         last_frame;

  assign last_frame = (frame == FRM_W'(HALF));
  assign commit     = take && last_frame;

  for (genvar f = 1; f <= HALF; f++) begin : g_pair
    localparam int LO = f - 1;
    localparam int HI = f - 1 + HALF;
    logic hit;
    assign hit = take && (frame == FRM_W'(f));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[LO] <= '0;
        pend_q[HI] <= '0;
      end else if (hit) begin
        pend_q[LO] <= octet[2*NIB_W-1:NIB_W];
        pend_q[HI] <= octet[NIB_W-1:0];
      end
    end

    // The last pair arrives in the commit cycle itself, so bypass the buffer.
    if (f == HALF) begin : g_bypass
      assign raw[LO] = commit ? octet[2*NIB_W-1:NIB_W] : pend_q[LO];
      assign raw[HI] = commit ? octet[NIB_W-1:0]       : pend_q[HI];
    end else begin : g_direct
      assign raw[LO] = pend_q[LO];
      assign raw[HI] = pend_q[HI];
    end
  end

  p_frame0_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && frame == '0) |=> $stable(pend_q));
endmodule

// File: rtl/e1cas_chan.sv
module e1cas_chan
  import e1cas_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [1:0]       mode,
  input  logic [NIB_W-1:0] raw,
  output logic [NIB_W-1:0] sig,
  output logic             changed
);
  logic [NIB_W-1:0] sig_q;
  logic [NIB_W-1:0] next_v;
  logic             active;

  assign active  = (mode != MODE_OFF);
  assign next_v  = mask_nibble(mode, raw);
  assign changed = commit && active && (next_v != sig_q);
  assign sig     = sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                sig_q <= '0;
    else if (commit && active) sig_q <= next_v;
  end

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && active) |=> $stable(sig_q));
  p_four_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && mode == MODE_4) |=> (sig_q[1:0] == 2'b00));
  p_two_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && mode == MODE_2) |=> (sig_q[2:0] == 3'b000));
endmodule

// File: rtl/e1cas_regs.sv
module e1cas_regs
  import e1cas_pkg::*;
#(
  parameter int NUM_CH = 30,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h20,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 6'h21
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [7:0]                   wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [7:0]                   rd_data,
  input  logic [NUM_CH-1:0][NIB_W-1:0] sig,
  input  logic                         any_change,
  output logic [NUM_CH-1:0][1:0]       mode,
  output logic                         irq
);
  logic [NUM_CH-1:0][1:0] mode_q;
  logic en_sig_q, en_blk_q, flag_q;
  logic clr;

  assign clr  = wr_en && (wr_addr == STAT_ADDR) && wr_data[0];
  assign mode = mode_q;
  assign irq  = flag_q && en_sig_q && en_blk_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
    always_ff @(posedge clk) begin
      if (!rst_n) mode_q[c] <= MODE_OFF;
      else if (wr_en && wr_addr == ADDR_W'(c)) mode_q[c] <= wr_data[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_sig_q <= 1'b0;
      en_blk_q <= 1'b0;
    end else if (wr_en && wr_addr == CTRL_ADDR) begin
      en_sig_q <= wr_data[0];
      en_blk_q <= wr_data[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (any_change) flag_q <= 1'b1;
    else if (clr)        flag_q <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = {mode_q[i], 2'b00, sig[i]};
    end
    if (rd_addr == CTRL_ADDR) rd_data = {6'b0, en_blk_q, en_sig_q};
    if (rd_addr == STAT_ADDR) rd_data = {7'b0, flag_q};
  end

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_change |=> flag_q);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !any_change) |=> !flag_q);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_blk_q || !en_sig_q) |-> !irq);
endmodule

// File: rtl/e1_cas_extract.sv
module e1_cas_extract
  import e1cas_pkg::*;
#(
  parameter int NUM_CH = 30,
  parameter int ADDR_W = 6,
  localparam int HALF  = NUM_CH / 2,
  localparam int FRM_W = $clog2(HALF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FRM_W-1:0]  in_frame,
  input  logic [7:0]        in_octet,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq
);
  logic                         take;
  logic                         commit;
  logic [NUM_CH-1:0][NIB_W-1:0] raw;
  logic [NUM_CH-1:0][NIB_W-1:0] sig;
  logic [NUM_CH-1:0][1:0]       mode;
  logic [NUM_CH-1:0]            chg;
  logic                         any_change;

  assign in_ready   = rst_n;
  assign take       = in_valid && in_ready;
  assign any_change = |chg;

  e1cas_capture #(.NUM_CH(NUM_CH)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(take), .frame(in_frame),
    .octet(in_octet), .raw(raw), .commit(commit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    e1cas_chan u_ch (
      .clk(clk), .rst_n(rst_n), .commit(commit), .mode(mode[c]),
      .raw(raw[c]), .sig(sig[c]), .changed(chg[c])
    );
  end

  e1cas_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sig(sig),
    .any_change(any_change), .mode(mode), .irq(irq)
  );

  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
  p_commit_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(sig));
endmodule

// File: tb/e1_cas_extract_tb.sv
module e1_cas_extract_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 30;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [3:0] in_frame = 0;
  logic [7:0] in_octet = 0;
  logic wr_en = 0;
  logic [5:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic irq;

  int n_run = 0, n_fail = 0;

  typedef struct {
    logic [5:0] addr;
    logic [7:0] exp;
    string      tag;
  } rd_item_t;
  rd_item_t q[$];

  logic [3:0] exp_sig [NCH];
  logic [1:0] exp_mode[NCH];
  logic exp_flag = 0, exp_en_sig = 0, exp_en_blk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_cas_extract u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_frame(in_frame), .in_octet(in_octet), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: owns rd_addr, pops expected read items and compares.
  initial begin
    forever begin
      wait (q.size() > 0);
      rd_addr = q[0].addr;
      #1;
      check(q[0].tag, rd_data, q[0].exp);
      void'(q.pop_front());
    end
  end

  task automatic expect_rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    q.push_back('{a, e, tag});
    wait (q.size() == 0);
  endtask

  function automatic logic [3:0] mask(input logic [1:0] m, input logic [3:0] r);
    case (m)
      2'b01: return r;
      2'b10: return {r[3:2], 2'b00};
      2'b11: return {r[3], 3'b000};
      default: return 4'h0;
    endcase
  endfunction

  task automatic reg_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a < 6'(NCH)) exp_mode[a] = d[1:0];
    if (a == 6'h20) begin exp_en_sig = d[0]; exp_en_blk = d[1]; end
    if (a == 6'h21 && d[0]) exp_flag = 0;
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NCH; i++)
      expect_rd(6'(i), {exp_mode[i], 2'b00, exp_sig[i]}, tag);
    expect_rd(6'h21, {7'b0, exp_flag}, {tag, " R10 status"});
    check({tag, " R11 irq"}, {7'b0, irq}, {7'b0, exp_flag & exp_en_sig & exp_en_blk});
  endtask

  task automatic send_mf(input logic [3:0] n[NCH], input logic [7:0] mfas, input bit clr_end);
    bit chg;
    for (int f = 0; f < 16; f++) begin
      @(negedge clk);
      if (f == 8) begin
        in_valid = 0;
        expect_rd(6'd0, {exp_mode[0], 2'b00, exp_sig[0]}, "R8 mid-multiframe hold");
        @(negedge clk);
      end
      in_valid = 1;
      in_frame = 4'(f);
      in_octet = (f == 0) ? mfas : {n[f-1], n[f+14]};
      if (f == 15 && clr_end) begin wr_en = 1; wr_addr = 6'h21; wr_data = 8'h01; end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; wr_en = 0;
    chg = 0;
    for (int i = 0; i < NCH; i++) begin
      if (exp_mode[i] != 2'b00) begin
        if (mask(exp_mode[i], n[i]) != exp_sig[i]) chg = 1;
        exp_sig[i] = mask(exp_mode[i], n[i]);
      end
    end
    if (chg) exp_flag = 1;
    else if (clr_end) exp_flag = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] p1[NCH], p2[NCH];
    for (int i = 0; i < NCH; i++) begin exp_sig[i] = 0; exp_mode[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    check("R1 in_ready", {7'b0, in_ready}, 8'h01);
    check("R1 irq", {7'b0, irq}, 8'h00);
    expect_rd(6'd0, 8'h00, "R1 ch1");
    expect_rd(6'd29, 8'h00, "R1 ch30");
    expect_rd(6'h20, 8'h00, "R1 ctrl");
    expect_rd(6'h21, 8'h00, "R1 status");

    // R12 configuration
    reg_wr(6'h20, 8'h03);
    expect_rd(6'h20, 8'h03, "R12 ctrl readback");
    for (int i = 0; i < 10; i++) reg_wr(6'(i), 8'h01);
    for (int i = 10; i < 20; i++) reg_wr(6'(i), 8'h02);
    for (int i = 20; i < 29; i++) reg_wr(6'(i), 8'h03);
    reg_wr(6'd29, 8'h00);

    // R3 R4 R5 R6 R9: first multiframe, new values everywhere
    for (int i = 0; i < NCH; i++) p1[i] = 4'((i * 7 + 3) & 15);
    send_mf(p1, 8'h0B, 0);
    check_all("R3 R4 R5 R6 R7 R9 mf1");

    // R10 clear
    reg_wr(6'h21, 8'h01);
    check_all("R10 after clear");

    // R9 R2 repeat with different alignment octet: no change
    send_mf(p1, 8'hFF, 0);
    check_all("R2 R9 repeat no change");

    // R5 R6 R7 masked-only differences: no flag
    for (int i = 0; i < NCH; i++) begin
      p2[i] = p1[i];
      if (i >= 10 && i < 20) p2[i] = p1[i] ^ 4'b0011;
      if (i >= 20 && i < 29) p2[i] = p1[i] ^ 4'b0111;
      if (i == 29) p2[i] = ~p1[i];
    end
    send_mf(p2, 8'h00, 0);
    check_all("R5 R6 R7 masked bits only");

    // R10 set wins over simultaneous clear
    p2[3] = ~p2[3];
    send_mf(p2, 8'h0B, 1);
    check_all("R10 set beats clear");

    // R11 block enable gating
    reg_wr(6'h20, 8'h01);
    check_all("R11 block enable off");
    reg_wr(6'h20, 8'h02);
    check_all("R11 signaling enable off");
    reg_wr(6'h20, 8'h03);
    check_all("R11 both enables on");

    // R7 channel returned to active mode picks up next value
    reg_wr(6'd29, 8'h01);
    reg_wr(6'h21, 8'h01);
    send_mf(p2, 8'h0B, 0);
    check_all("R7 R9 channel 30 re-enabled");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule